// File: doc/BRIEF.md
# DES Round Unit

This block is a DES execution resource for a processor pipeline. Each time it is issued, it reads a sixteen-byte register window and runs exactly one DES round. The low eight bytes of the window hold the data block and the high eight bytes hold the key. The unit returns the whole updated window one clock later, and the surrounding core writes it back to the same registers. Software runs the unit sixteen times in a row, tagging each issue with its round number 0 to 15. After the sixteenth issue the data bytes hold the finished ciphertext, or the finished plaintext when decrypting.

The window carries the state from one round to the next. The data registers hold the two Feistel halves. The key registers hold the rotated 56-bit key-schedule state. Because of this, the unit itself keeps nothing between issues apart from its output register. Round 0 and round 15 are special. On round 0 the unit applies the initial permutation and the parity-dropping key selection. On round 15 it skips the half swap and applies the final permutation.

Top module: `des_round_unit`

## Requirements
- R1: When `issue` is high at a rising clock edge, `wb_valid` is high after that edge, and `wb_win` carries the result of that round.
- R2: In the window, byte k sits at bits 8k+7..8k. Bytes 0..7 hold the data block, with the least significant data bit in bit 0 of byte 0. Bytes 8..15 hold the key, parity bits included, in the same LSB-first order. In this layout, standard DES bit 1 is the most significant bit of each 64-bit word.
- R3: On round 0 the data word passes through the initial permutation, and the key word passes through permuted choice 1, which drops the eight parity bits. Between rounds the key word holds C in bits 63..36, D in bits 35..8 and zero in bits 7..0.
- R4: On rounds 0..14 the written data word has the old right half in bits 63..32 and (old left XOR f) in bits 31..0.
- R5: On round 15 the halves are not swapped. The written data word is the final permutation of {left XOR f, right}.
- R6: When encrypting, C and D rotate left by 1 on rounds 0, 1, 8 and 15 and by 2 on the other rounds, before the subkey is selected. After round 15 the key word is back to its post-selection value.
- R7: When decrypting (`decrypt` high), round 0 does not rotate. After that, C and D rotate right by 1 on rounds 1, 8 and 15 and by 2 on the other rounds. Sixteen decrypt rounds applied to a ciphertext give back the plaintext.
- R8: A synchronous reset clears `wb_valid` and `wb_win` to zero.
- R9: When `issue` is low, `wb_valid` goes low and `wb_win` keeps its value, whatever the window input does.
- R10: Sixteen encrypt rounds applied to standard DES known-answer inputs produce the standard ciphertexts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Run one round on the current window |
| decrypt | input | 1 | 1 = decryption key schedule, 0 = encryption |
| round | input | 4 | Round number 0..15 |
| win_rd | input | 128 | Register window read: data bytes 0..7, key bytes 8..15 |
| wb_valid | output | 1 | Write-back strobe, one cycle after issue |
| wb_win | output | 128 | Updated window to write back |

## Verification
The bench targets the round-0 and round-15 special cases. An error in the initial permutation or the key selection shows up as a wrong round-0 data or key word. A swap applied on the last round, or a missing final permutation, makes every final block wrong. The bench also checks the key word against known values after round 0 and after round 15, in both directions. A decrypt schedule that rotates on round 0, or that rotates left, moves the key away from those values. Idle cycles with a changing window expose an output register that is loaded without `issue`. A reset in the middle of a block checks that the unit recovers.

// File: rtl/des_pkg.sv
package des_pkg;

  localparam int unsigned BLK_W  = 64;
  localparam int unsigned HALF_W = BLK_W / 2;
  localparam int unsigned CD_W   = 56;
  localparam int unsigned HCD_W  = CD_W / 2;
  localparam int unsigned SK_W   = 48;
  localparam int unsigned WIN_W  = 2 * BLK_W;
  localparam int unsigned PAD_W  = BLK_W - CD_W;
  localparam int unsigned RND_W  = 4;
  localparam int unsigned N_BOX  = 8;
  localparam int unsigned BOX_IN = SK_W / N_BOX;
  localparam int unsigned BOX_OUT = HALF_W / N_BOX;

  // Initial permutation, entries are 1-based source bit numbers (bit 1 = MSB)
  localparam logic [7:0] IP_T [BLK_W] = '{
    58, 50, 42, 34, 26, 18, 10, 2,  60, 52, 44, 36, 28, 20, 12, 4,
    62, 54, 46, 38, 30, 22, 14, 6,  64, 56, 48, 40, 32, 24, 16, 8,
    57, 49, 41, 33, 25, 17,  9, 1,  59, 51, 43, 35, 27, 19, 11, 3,
    61, 53, 45, 37, 29, 21, 13, 5,  63, 55, 47, 39, 31, 23, 15, 7};

  localparam logic [7:0] P_T [HALF_W] = '{
    16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
     2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

  localparam logic [7:0] PC1_T [CD_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  localparam logic [7:0] PC2_T [SK_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // Substitution boxes: one 64-bit word per row, column 0 in the top nibble.
  // Index = box*4 + row.
  localparam logic [63:0] SBOX_ROWS [4*N_BOX] = '{
    64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D,
    64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9,
    64'hA09E63F51DC7B428, 64'hD709346A285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C,
    64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E,
    64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453,
    64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D,
    64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C,
    64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B};

  function automatic logic [BLK_W-1:0] ip_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-int'(IP_T[i])];
    return y;
  endfunction

  // Final permutation is the inverse of the initial one
  function automatic logic [BLK_W-1:0] fp_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-int'(IP_T[i])] = x[BLK_W-1-i];
    return y;
  endfunction

  // Expansion: group g takes source bits 4g..4g+5 (1-based, wrapping)
  function automatic logic [SK_W-1:0] expand(input logic [HALF_W-1:0] x);
    logic [SK_W-1:0] y;
    for (int i = 0; i < SK_W; i++) begin
      int src;
      src = 4 * (i / 6) + (i % 6);
      if (src == 0) src = HALF_W;
      if (src > HALF_W) src = 1;
      y[SK_W-1-i] = x[HALF_W-src];
    end
    return y;
  endfunction

  function automatic logic [HALF_W-1:0] p_perm(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-int'(P_T[i])];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] pc1_sel(input logic [BLK_W-1:0] x);
    logic [CD_W-1:0] y;
    for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = x[BLK_W-int'(PC1_T[i])];
    return y;
  endfunction

  function automatic logic [SK_W-1:0] pc2_sel(input logic [CD_W-1:0] x);
    logic [SK_W-1:0] y;
    for (int i = 0; i < SK_W; i++) y[SK_W-1-i] = x[CD_W-int'(PC2_T[i])];
    return y;
  endfunction

endpackage

// File: rtl/des_sbox.sv
module des_sbox
  import des_pkg::*;
#(
  parameter int unsigned BOX = 0
) (
  input  logic [BOX_IN-1:0]  six,
  output logic [BOX_OUT-1:0] four
);

  localparam int unsigned BASE = BOX * 4;

  logic [1:0]  row;
  logic [3:0]  col;
  logic [63:0] row_word;

  always_comb begin
    row      = {six[5], six[0]};
    col      = six[4:1];
    row_word = SBOX_ROWS[BASE + int'(row)];
    four     = row_word[{~col, 2'b00} +: 4];
  end

endmodule

// File: rtl/des_feistel.sv
module des_feistel
  import des_pkg::*;
(
  input  logic [HALF_W-1:0] half_in,
  input  logic [SK_W-1:0]   subkey,
  output logic [HALF_W-1:0] f_out
);

  logic [SK_W-1:0]   mixed;
  logic [HALF_W-1:0] subst;

  always_comb mixed = expand(half_in) ^ subkey;

  for (genvar b = 0; b < N_BOX; b++) begin : g_box
    des_sbox #(.BOX(b)) u_box (
      .six  (mixed[SK_W-1-BOX_IN*b -: BOX_IN]),
      .four (subst[HALF_W-1-BOX_OUT*b -: BOX_OUT])
    );
  end

  always_comb f_out = p_perm(subst);

endmodule

// File: rtl/des_keysched.sv
module des_keysched
  import des_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             decrypt,
  input  logic [RND_W-1:0] round,
  input  logic [BLK_W-1:0] key_word,
  output logic [CD_W-1:0]  cd_next,
  output logic [SK_W-1:0]  subkey
);

  logic [CD_W-1:0]  cd_cur;
  logic [HCD_W-1:0] c_cur, d_cur, c_nxt, d_nxt;
  logic [1:0]       amt;
  logic             single;

  function automatic logic [HCD_W-1:0] rot(input logic [HCD_W-1:0] x,
                                          input logic [1:0] n, input logic right);
    logic [HCD_W-1:0] y;
    case ({right, n})
      3'b001:  y = {x[HCD_W-2:0], x[HCD_W-1]};
      3'b010:  y = {x[HCD_W-3:0], x[HCD_W-1 -: 2]};
      3'b101:  y = {x[0], x[HCD_W-1:1]};
      3'b110:  y = {x[1:0], x[HCD_W-1:2]};
      default: y = x;
    endcase
    return y;
  endfunction

  always_comb begin
    cd_cur = (round == '0) ? pc1_sel(key_word) : key_word[BLK_W-1 -: CD_W];
    c_cur  = cd_cur[CD_W-1 -: HCD_W];
    d_cur  = cd_cur[HCD_W-1:0];
    single = (round == 4'd0) || (round == 4'd1) || (round == 4'd8) || (round == 4'd15);
    if (decrypt && round == '0) amt = 2'd0;
    else if (single)            amt = 2'd1;
    else                        amt = 2'd2;
    c_nxt   = rot(c_cur, amt, decrypt);
    d_nxt   = rot(d_cur, amt, decrypt);
    cd_next = {c_nxt, d_nxt};
    subkey  = pc2_sel(cd_next);
  end

  // R6: rotation only moves key bits, never creates or drops them
  p_rot_keeps_bits_r6: assert property (@(posedge clk) disable iff (rst)
    issue |-> ($countones(cd_next) == $countones(cd_cur)));

  // R7: decryption starts from the unrotated post-selection key
  p_dec_first_no_shift_r7: assert property (@(posedge clk) disable iff (rst)
    (issue && decrypt && round == '0) |-> (cd_next == cd_cur));

endmodule

// File: rtl/des_round_unit.sv
module des_round_unit
  import des_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             decrypt,
  input  logic [RND_W-1:0] round,
  input  logic [WIN_W-1:0] win_rd,
  output logic             wb_valid,
  output logic [WIN_W-1:0] wb_win
);

  logic [BLK_W-1:0]  din, kin, lr, blk_next, chk_ip;
  logic [HALF_W-1:0] l_cur, r_cur, f_val, mix;
  logic [CD_W-1:0]   cd_next;
  logic [SK_W-1:0]   subkey;
  logic              last;

  always_comb begin
    din   = win_rd[BLK_W-1:0];
    kin   = win_rd[WIN_W-1:BLK_W];
    last  = (round == '1);
    lr    = (round == '0) ? ip_perm(din) : din;
    l_cur = lr[BLK_W-1:HALF_W];
    r_cur = lr[HALF_W-1:0];
  end

  des_keysched u_keys (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .decrypt  (decrypt),
    .round    (round),
    .key_word (kin),
    .cd_next  (cd_next),
    .subkey   (subkey)
  );

  des_feistel u_f (
    .half_in (r_cur),
    .subkey  (subkey),
    .f_out   (f_val)
  );

  always_comb begin
    mix      = l_cur ^ f_val;
    blk_next = last ? fp_perm({mix, r_cur}) : {r_cur, mix};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_win   <= '0;
    end else begin
      wb_valid <= issue;
      if (issue) wb_win <= {cd_next, {PAD_W{1'b0}}, blk_next};
    end
  end

  always_comb chk_ip = ip_perm(wb_win[BLK_W-1:0]);

  // R1: one-cycle write-back strobe
  p_valid_follows_issue_r1: assert property (@(posedge clk) disable iff (rst)
    issue |=> wb_valid);

  // R9: idle cycles leave the write-back untouched
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !issue |=> (!wb_valid && $stable(wb_win)));

  // R4: middle rounds move the right half into the left slot
  p_swap_mid_r4: assert property (@(posedge clk) disable iff (rst)
    (issue && !last) |=> (wb_win[BLK_W-1:HALF_W] == $past(r_cur)));

  // R5: last round keeps the right half in place beneath the final permutation
  p_no_swap_last_r5: assert property (@(posedge clk) disable iff (rst)
    (issue && last) |=> (chk_ip[HALF_W-1:0] == $past(r_cur)));

endmodule

// File: tb/des_round_unit_bench.sv
module des_round_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         issue = 1'b0;
  logic         decrypt = 1'b0;
  logic [3:0]   round = '0;
  logic [127:0] win_rd = '0;
  logic         wb_valid;
  logic [127:0] wb_win;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit mon_en  = 0;
  bit exp_valid_q = 0;
  logic [127:0] prev_win = '0;
  logic [127:0] res_r0, res_r15;
  logic [7:0]   rf [16];

  des_round_unit u_des_round_unit (
    .clk(clk), .rst(rst), .issue(issue), .decrypt(decrypt), .round(round),
    .win_rd(win_rd), .wb_valid(wb_valid), .wb_win(wb_win)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural cycle model: strobe expected one clock after issue
  always @(posedge clk) exp_valid_q <= rst ? 1'b0 : issue;

  always @(negedge clk) begin
    if (mon_en) begin
      check(wb_valid == exp_valid_q, "R1", "per-cycle strobe", 128'(wb_valid), 128'(exp_valid_q));
      if (!exp_valid_q) check(wb_win == prev_win, "R9", "idle hold", wb_win, prev_win);
      prev_win = wb_win;
    end
  end

  function automatic logic [127:0] pack_rf();
    logic [127:0] w;
    for (int k = 0; k < 16; k++) w[8*k +: 8] = rf[k];
    return w;
  endfunction

  task automatic drive(input int r, input bit dec);
    issue   = 1'b1;
    decrypt = dec;
    round   = 4'(r);
    win_rd  = pack_rf();
  endtask

  // R2: bytes loaded one at a time, data LSB-first in bytes 0..7, key in 8..15
  task automatic run_block(input logic [63:0] key, input logic [63:0] data, input bit dec);
    for (int k = 0; k < 8; k++) begin
      rf[k]   = data[8*k +: 8];
      rf[k+8] = key[8*k +: 8];
    end
    @(negedge clk);
    drive(0, dec);
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      for (int k = 0; k < 16; k++) rf[k] = wb_win[8*k +: 8];
      if (r == 0)  res_r0  = wb_win;
      if (r == 15) res_r15 = wb_win;
      if (r < 15) drive(r + 1, dec);
      else issue = 1'b0;
    end
  endtask

  task automatic kat(input logic [63:0] key, input logic [63:0] pt, input logic [63:0] ct);
    run_block(key, pt, 1'b0);
    check(res_r15[63:0] == ct, "R10", "encrypt known answer", 128'(res_r15[63:0]), 128'(ct));
    run_block(key, ct, 1'b1);
    check(res_r15[63:0] == pt, "R7", "decrypt known answer", 128'(res_r15[63:0]), 128'(pt));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check(wb_valid == 1'b0, "R8", "valid after reset", 128'(wb_valid), 128'(0));
    check(wb_win == '0, "R8", "window after reset", wb_win, '0);
    prev_win = wb_win;
    mon_en = 1;

    // Worked example: encrypt with intermediate checks
    run_block(64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 1'b0);
    check(res_r0[63:0] == 64'hF0AAF0AAEF4A6544, "R4", "round0 data halves",
          128'(res_r0[63:0]), 128'(64'hF0AAF0AAEF4A6544));
    check(res_r0[127:64] == 64'hE19955FAACCF1E00, "R3", "round0 key state",
          128'(res_r0[127:64]), 128'(64'hE19955FAACCF1E00));
    check(res_r15[127:64] == 64'hF0CCAAF556678F00, "R6", "key after 16 left rotations",
          128'(res_r15[127:64]), 128'(64'hF0CCAAF556678F00));
    check(res_r15[63:0] == 64'h85E813540F0AB405, "R5", "final permutation output",
          128'(res_r15[63:0]), 128'(64'h85E813540F0AB405));
    check(res_r15[7:0] == 8'h05 && res_r15[63:56] == 8'h85, "R2", "ciphertext byte lanes",
          128'(res_r15[63:0]), 128'(64'h85E813540F0AB405));

    // Worked example: decrypt with key-state checks
    run_block(64'h133457799BBCDFF1, 64'h85E813540F0AB405, 1'b1);
    check(res_r0[127:64] == 64'hF0CCAAF556678F00, "R7", "decrypt round0 no rotation",
          128'(res_r0[127:64]), 128'(64'hF0CCAAF556678F00));
    check(res_r15[127:64] == 64'hE19955FAACCF1E00, "R7", "decrypt key after 27 right steps",
          128'(res_r15[127:64]), 128'(64'hE19955FAACCF1E00));
    check(res_r15[63:0] == 64'h0123456789ABCDEF, "R7", "decrypt worked example",
          128'(res_r15[63:0]), 128'(64'h0123456789ABCDEF));

    kat(64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0000000000000000);
    kat(64'h0000000000000000, 64'h0000000000000000, 64'h8CA64DE9C1B123A7);

    // R9: idle with a changing window leaves output untouched
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      win_rd = {$urandom, $urandom, $urandom, $urandom};
      round  = 4'($urandom);
    end
    @(negedge clk);
    check(wb_win == res_r15 && !wb_valid, "R9", "idle window ignored", wb_win, res_r15);

    // R8: reset in the middle of a block
    for (int k = 0; k < 16; k++) rf[k] = 8'(k * 17 + 3);
    @(negedge clk);
    drive(0, 1'b0);
    @(negedge clk);
    drive(1, 1'b0);
    @(negedge clk);
    issue = 1'b0;
    mon_en = 0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(wb_valid == 1'b0, "R8", "valid after mid-block reset", 128'(wb_valid), 128'(0));
    check(wb_win == '0, "R8", "window after mid-block reset", wb_win, '0);
    prev_win = wb_win;
    mon_en = 1;
    run_block(64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 1'b0);
    check(res_r15[63:0] == 64'h85E813540F0AB405, "R10", "encrypt after reset",
          128'(res_r15[63:0]), 128'(64'h85E813540F0AB405));

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule